// File: doc/BRIEF.md
# Serial Latched-Driver Chain Loader

This block sits on the host side of a daisy chain of 8-bit serial-input, latched high-side driver devices. A single start request and a parallel word of one bit per driver output are turned into the four control lines the chain needs: a shift clock, serial data, a latch strobe and an active-high blanking line. The blanking line forces every driver output off while it is high. Every edge on these lines is placed on the system clock. Each interval the drivers require is derived at elaboration time from a nanosecond minimum and the system clock period, rounded up to whole cycles. The intervals are data setup and hold around the shift-clock rise, the clock high and low widths, the guard time from the last clock edge to the strobe, and the strobe width.

Two latch modes are supported and chosen per load. In latched mode the strobe stays low while the bits shift, and the drivers keep showing the previous word. One strobe pulse then moves the new word into the latches. In bypass mode the strobe is held high all the time, so the latches are transparent. The controller then holds blanking high across the whole shift and the guard time, so partly shifted data never reaches a load. The block reports busy while a load is in progress and pulses done when the load ends.

Top module: `drvchain_loader`

## Requirements
- R1: After reset, with bypass low, the shift clock, strobe, blanking, busy and done outputs are all low.
- R2: A load makes exactly DEVICES×STAGES shift-clock rises. Word bit W-1 is sent first and bit 0 last. After the load, chain position i (position 0 nearest the host, position W-1 the last output of the farthest device) holds word bit i.
- R3: Serial data changes only at the start of a clock-low phase. It is stable for at least ceil(T_SETUP_NS/SYS_CLK_NS) cycles (4 at defaults) before each rise.
- R4: Serial data does not change while the shift clock is high, and it stays unchanged for at least ceil(T_HOLD_NS/SYS_CLK_NS) cycles (4) after each rise.
- R5: Every shift-clock high phase and every low phase that precedes a rise lasts exactly max(clock width, setup or hold) cycles, which is 8 and 8 at defaults. The shift clock is low whenever busy is low.
- R6: In latched mode the strobe rises exactly ceil(T_GUARD_NS/SYS_CLK_NS) cycles (15) after the last shift-clock fall.
- R7: In latched mode the strobe is high for exactly ceil(T_STROBE_NS/SYS_CLK_NS) cycles (5) and low during shifting. Blanking stays low, and the driver outputs keep the previous word until the strobe.
- R8: In bypass mode the strobe stays high throughout the load. Blanking rises with the first data bit, before the first clock rise, and falls exactly 15 cycles after the last clock fall. No strobe pulse is produced.
- R9: A start request while busy is ignored. The load in progress finishes with its own word and no extra clock rises.
- R10: Done is high for exactly one cycle per load, with busy low in that cycle. Busy lasts W×16+15+5 cycles in latched mode and W×16+15 cycles in bypass mode. A start request in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | One-cycle start request, taken when idle or in the done cycle |
| latch_bypass | input | 1 | 1 selects transparent-latch mode; captured at start |
| load_word | input | DEVICES×STAGES | Word to load; bit i drives chain position i |
| drv_clk | output | 1 | Shift clock to the chain |
| drv_data | output | 1 | Serial data to the first device |
| drv_latch | output | 1 | Latch strobe |
| drv_blank | output | 1 | Output blanking, high turns all driver outputs off |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse at the end of a load |

## Verification
The bench loads a two-device chain model with a mixed pattern, all ones, all zeros, and single set bits at each end of the word. The single-bit words show whether the bit order is reversed or off by one, and the uniform words show whether the clock count is right when data never toggles. A monitor measures every edge interval against the derived cycle counts. A load of a second word checks that the old outputs hold until the strobe, and a bypass load checks that blanking hides the transparent latches. Further tests retrigger the start request mid-load and fire it again in the done cycle, which separate ignored requests from accepted back-to-back ones.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_GUARD,
    ST_STB,
    ST_FIN
  } dcl_state_e;

  function automatic int cyc_ceil(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dcl_shifter.sv
module dcl_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] word,
  output logic         msb
);

  logic [W-1:0] sreg;

  generate
    if (W > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)        sreg <= '0;
        else if (load)  sreg <= word;
        else if (shift) sreg <= {sreg[W-2:0], 1'b0};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst)       sreg <= '0;
        else if (load) sreg <= word;
      end
    end
  endgenerate

  assign msb = sreg[W-1];

endmodule

// File: rtl/dcl_interval.sv
module dcl_interval #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/dcl_seq.sv
module dcl_seq
  import dcl_pkg::*;
#(
  parameter int W         = 16,
  parameter int LO_LEN    = 8,
  parameter int HI_LEN    = 8,
  parameter int GUARD_LEN = 15,
  parameter int STB_LEN   = 5,
  parameter int CW        = 4,
  parameter int BW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          bypass,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          sh_load,
  output logic          sh_shift,
  output logic          drv_clk,
  output logic          drv_latch,
  output logic          drv_blank,
  output logic          busy,
  output logic          done
);

  dcl_state_e    state, state_n;
  logic [BW-1:0] bits_left, bits_left_n;
  logic          byp_q, byp_n;
  logic          idle_n;
  logic          shifting_n;

  always_comb begin
    state_n     = state;
    bits_left_n = bits_left;
    byp_n       = byp_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    sh_load     = 1'b0;
    sh_shift    = 1'b0;
    case (state)
      ST_IDLE, ST_FIN: begin
        if (start) begin
          state_n     = ST_LO;
          bits_left_n = BW'(W - 1);
          byp_n       = bypass;
          sh_load     = 1'b1;
          tmr_load    = 1'b1;
          tmr_val     = CW'(LO_LEN - 1);
        end else begin
          state_n = ST_IDLE;
        end
      end
      ST_LO: begin
        if (tmr_zero) begin
          state_n  = ST_HI;
          tmr_load = 1'b1;
          tmr_val  = CW'(HI_LEN - 1);
        end
      end
      ST_HI: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (bits_left == '0) begin
            state_n = ST_GUARD;
            tmr_val = CW'(GUARD_LEN - 1);
          end else begin
            state_n     = ST_LO;
            bits_left_n = bits_left - 1'b1;
            sh_shift    = 1'b1;
            tmr_val     = CW'(LO_LEN - 1);
          end
        end
      end
      ST_GUARD: begin
        if (tmr_zero) begin
          if (byp_q) begin
            state_n = ST_FIN;
          end else begin
            state_n  = ST_STB;
            tmr_load = 1'b1;
            tmr_val  = CW'(STB_LEN - 1);
          end
        end
      end
      ST_STB: begin
        if (tmr_zero) state_n = ST_FIN;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign idle_n     = (state_n == ST_IDLE) || (state_n == ST_FIN);
  assign shifting_n = (state_n == ST_LO) || (state_n == ST_HI) || (state_n == ST_GUARD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bits_left <= '0;
      byp_q     <= 1'b0;
      drv_clk   <= 1'b0;
      drv_latch <= 1'b0;
      drv_blank <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= state_n;
      bits_left <= bits_left_n;
      byp_q     <= byp_n;
      drv_clk   <= (state_n == ST_HI);
      drv_latch <= idle_n ? bypass : (byp_n || (state_n == ST_STB));
      drv_blank <= byp_n && shifting_n;
      busy      <= !idle_n;
      done      <= (state_n == ST_FIN);
    end
  end

endmodule

// File: rtl/drvchain_loader.sv
module drvchain_loader
  import dcl_pkg::*;
#(
  parameter int DEVICES     = 2,
  parameter int STAGES      = 8,
  parameter int SYS_CLK_NS  = 20,
  parameter int T_SETUP_NS  = 75,
  parameter int T_HOLD_NS   = 75,
  parameter int T_CLKHI_NS  = 150,
  parameter int T_CLKLO_NS  = 150,
  parameter int T_GUARD_NS  = 300,
  parameter int T_STROBE_NS = 100
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load_req,
  input  logic                        latch_bypass,
  input  logic [DEVICES*STAGES-1:0]   load_word,
  output logic                        drv_clk,
  output logic                        drv_data,
  output logic                        drv_latch,
  output logic                        drv_blank,
  output logic                        busy,
  output logic                        done
);

  localparam int W         = DEVICES * STAGES;
  localparam int SETUP_C   = cyc_ceil(T_SETUP_NS, SYS_CLK_NS);
  localparam int HOLD_C    = cyc_ceil(T_HOLD_NS, SYS_CLK_NS);
  localparam int LO_LEN    = imax(cyc_ceil(T_CLKLO_NS, SYS_CLK_NS), SETUP_C);
  localparam int HI_LEN    = imax(cyc_ceil(T_CLKHI_NS, SYS_CLK_NS), HOLD_C);
  localparam int GUARD_LEN = imax(cyc_ceil(T_GUARD_NS, SYS_CLK_NS), 1);
  localparam int STB_LEN   = imax(cyc_ceil(T_STROBE_NS, SYS_CLK_NS), 1);
  localparam int MAX_LEN   = imax(imax(LO_LEN, HI_LEN), imax(GUARD_LEN, STB_LEN));
  localparam int CW        = $clog2(MAX_LEN + 1);
  localparam int BW        = (W > 1) ? $clog2(W) : 1;

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          sh_load;
  logic          sh_shift;

  dcl_interval #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  dcl_shifter #(.W(W)) u_shf (
    .clk   (clk),
    .rst   (rst),
    .load  (sh_load),
    .shift (sh_shift),
    .word  (load_word),
    .msb   (drv_data)
  );

  dcl_seq #(
    .W         (W),
    .LO_LEN    (LO_LEN),
    .HI_LEN    (HI_LEN),
    .GUARD_LEN (GUARD_LEN),
    .STB_LEN   (STB_LEN),
    .CW        (CW),
    .BW        (BW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (load_req),
    .bypass    (latch_bypass),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .sh_load   (sh_load),
    .sh_shift  (sh_shift),
    .drv_clk   (drv_clk),
    .drv_latch (drv_latch),
    .drv_blank (drv_blank),
    .busy      (busy),
    .done      (done)
  );

endmodule

// File: rtl/dcl_checker.sv
module dcl_checker #(
  parameter int HI_LEN = 8,
  parameter int LO_LEN = 8
) (
  input logic clk,
  input logic rst,
  input logic drv_clk,
  input logic drv_data,
  input logic drv_latch,
  input logic drv_blank,
  input logic busy,
  input logic done
);

  logic [15:0] hi_run;
  logic [15:0] lo_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= drv_clk ? hi_run + 16'd1 : 16'd0;
      lo_run <= (!drv_clk && busy) ? lo_run + 16'd1 : 16'd0;
    end
  end

  AST_DATA_STILL_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
    drv_clk |-> $stable(drv_data)); // R4

  AST_CLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (!drv_clk && hi_run != 16'd0) |-> (hi_run == 16'(HI_LEN))); // R5

  AST_CLK_LOW_BEFORE_RISE: assert property (@(posedge clk) disable iff (rst)
    (drv_clk && lo_run != 16'd0) |-> (lo_run == 16'(LO_LEN))); // R5

  AST_CLK_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !drv_clk); // R5

  AST_OPEN_LATCH_BLANKED: assert property (@(posedge clk) disable iff (rst)
    (drv_latch && drv_clk) |-> drv_blank); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10

endmodule

bind drvchain_loader dcl_checker #(.HI_LEN(HI_LEN), .LO_LEN(LO_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .drv_clk   (drv_clk),
  .drv_data  (drv_data),
  .drv_latch (drv_latch),
  .drv_blank (drv_blank),
  .busy      (busy),
  .done      (done)
);

// File: tb/sim_drvchain_loader.sv
module sim_drvchain_loader;

  localparam int W       = 16;
  localparam int PER     = 20;
  localparam int SETUP_C = (75 + PER - 1) / PER;
  localparam int HOLD_C  = (75 + PER - 1) / PER;
  localparam int LO_C    = 8;
  localparam int HI_C    = 8;
  localparam int GUARD_C = (300 + PER - 1) / PER;
  localparam int STB_C   = (100 + PER - 1) / PER;
  localparam int BUSY_N  = W * (LO_C + HI_C) + GUARD_C + STB_C;
  localparam int BUSY_X  = W * (LO_C + HI_C) + GUARD_C;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_req = 1'b0;
  logic         latch_bypass = 1'b0;
  logic [W-1:0] load_word = '0;
  logic         drv_clk, drv_data, drv_latch, drv_blank, busy, done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  drvchain_loader u0 (
    .clk          (clk),
    .rst          (rst),
    .load_req     (load_req),
    .latch_bypass (latch_bypass),
    .load_word    (load_word),
    .drv_clk      (drv_clk),
    .drv_data     (drv_data),
    .drv_latch    (drv_latch),
    .drv_blank    (drv_blank),
    .busy         (busy),
    .done         (done)
  );

  // chain model and interval monitor
  int           cyc = 0;
  logic [W-1:0] chain = '0, latch = '0, snap = '0, vis;
  logic         p_clk = 0, p_data = 0, p_latch = 0, p_blank = 0, p_busy = 0, p_done = 0;
  logic         cur_xp = 0;
  int last_fall = 0, last_rise = -100000, last_dchg = 0, stb_rise = 0;
  int n_rise = 0, busy_run = 0, done_seen = 0;
  int v3 = 0, v4 = 0, v5 = 0, v6 = 0, v7 = 0, v8 = 0, v10 = 0;

  assign vis = drv_blank ? '0 : latch;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (busy && !p_busy) begin
        last_fall = cyc; last_rise = -100000; n_rise = 0; busy_run = 0; snap = latch;
      end
      if (busy) busy_run++;
      if (drv_clk && !p_clk) begin
        n_rise++;
        if (cyc - last_fall != LO_C) v5++;
        if (cyc - last_dchg < SETUP_C) v3++;
        if (!cur_xp && latch != snap) v7++;
        if (cur_xp && !drv_blank) v8++;
        chain = {chain[W-2:0], drv_data};
        last_rise = cyc;
      end
      if (!drv_clk && p_clk) begin
        if (cyc - last_rise != HI_C) v5++;
        last_fall = cyc;
      end
      if (!busy && drv_clk) v5++;
      if (drv_data != p_data) begin
        if (drv_clk) v4++;
        if (cyc - last_rise < HOLD_C) v4++;
        last_dchg = cyc;
      end
      if (drv_latch && !p_latch && busy && !cur_xp) begin
        if (cyc - last_fall != GUARD_C) v6++;
        stb_rise = cyc;
      end
      if (!drv_latch && p_latch && p_busy && !cur_xp)
        if (cyc - stb_rise != STB_C) v7++;
      if (!cur_xp && drv_latch && busy && drv_clk) v7++;
      if (!cur_xp && drv_blank) v7++;
      if (cur_xp && busy && !drv_latch) v8++;
      if (!drv_blank && p_blank)
        if (cyc - last_fall != GUARD_C) v8++;
      if (drv_latch) latch = chain;
      if (done) begin
        done_seen++;
        if (busy) v10++;
        if (p_done) v10++;
        if (busy_run != (cur_xp ? BUSY_X : BUSY_N)) v10++;
      end
    end
    p_clk = drv_clk; p_data = drv_data; p_latch = drv_latch;
    p_blank = drv_blank; p_busy = busy; p_done = done;
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_intervals(input string tag);
    check("R3", {tag, " setup"}, 64'(v3), 64'd0);
    check("R4", {tag, " hold"}, 64'(v4), 64'd0);
    check("R5", {tag, " clock widths"}, 64'(v5), 64'd0);
    check("R6", {tag, " guard"}, 64'(v6), 64'd0);
    check("R7", {tag, " strobe/hold-old"}, 64'(v7), 64'd0);
    check("R8", {tag, " bypass blanking"}, 64'(v8), 64'd0);
    check("R10", {tag, " done/busy"}, 64'(v10), 64'd0);
    v3 = 0; v4 = 0; v5 = 0; v6 = 0; v7 = 0; v8 = 0; v10 = 0;
  endtask

  task automatic pulse_start(input logic [W-1:0] w, input logic xp);
    @(negedge clk);
    load_word = w; latch_bypass = xp; cur_xp = xp; load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) return;
    end
    check("R10", "done timeout", 64'd0, 64'd1);
  endtask

  task automatic t_reset();
    check("R1", "drv_clk", 64'(drv_clk), 64'd0);
    check("R1", "drv_latch", 64'(drv_latch), 64'd0);
    check("R1", "drv_blank", 64'(drv_blank), 64'd0);
    check("R1", "busy", 64'(busy), 64'd0);
    check("R1", "done", 64'(done), 64'd0);
  endtask

  task automatic t_load(input logic [W-1:0] w, input logic xp, input string tag);
    int d0;
    d0 = done_seen;
    pulse_start(w, xp);
    wait_done();
    repeat (2) @(negedge clk);
    check("R2", {tag, " outputs"}, 64'(vis), 64'(w));
    check("R2", {tag, " clock count"}, 64'(n_rise), 64'(W));
    check("R10", {tag, " done count"}, 64'(done_seen - d0), 64'd1);
    check_intervals(tag);
  endtask

  task automatic t_hold_old();
    t_load(16'h3C0F, 1'b0, "hold-old A");
    pulse_start(16'hC3F0, 1'b0);
    repeat (120) @(negedge clk);
    check("R7", "old word while shifting", 64'(vis), 64'h3C0F);
    check("R7", "blank low in latched mode", 64'(drv_blank), 64'd0);
    wait_done();
    repeat (2) @(negedge clk);
    check("R7", "new word after strobe", 64'(vis), 64'hC3F0);
    check_intervals("hold-old B");
  endtask

  task automatic t_busy_ignore();
    pulse_start(16'h1234, 1'b0);
    repeat (60) @(negedge clk);
    load_word = 16'hFEDC; load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    repeat (100) @(negedge clk);
    load_word = 16'h0F0F; load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    check("R9", "word kept", 64'(vis), 64'h1234);
    check("R9", "no extra clocks", 64'(n_rise), 64'(W));
    check("R9", "idle after load", 64'(busy), 64'd0);
    check_intervals("busy-ignore");
  endtask

  task automatic t_back_to_back();
    int d0;
    d0 = done_seen;
    pulse_start(16'h8001, 1'b0);
    wait_done();
    load_word = 16'h7FFE; load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    check("R10", "busy after done-cycle start", 64'(busy), 64'd1);
    wait_done();
    repeat (2) @(negedge clk);
    check("R10", "second word loaded", 64'(vis), 64'h7FFE);
    check("R10", "two done pulses", 64'(done_seen - d0), 64'd2);
    check_intervals("back-to-back");
  endtask

  task automatic t_bypass();
    @(negedge clk);
    latch_bypass = 1'b1; cur_xp = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", "strobe high idle", 64'(drv_latch), 64'd1);
    pulse_start(16'h5AA5, 1'b1);
    repeat (100) @(negedge clk);
    check("R8", "blank mid-shift", 64'(drv_blank), 64'd1);
    check("R8", "outputs dark mid-shift", 64'(vis), 64'd0);
    check("R8", "strobe mid-shift", 64'(drv_latch), 64'd1);
    wait_done();
    repeat (2) @(negedge clk);
    check("R8", "outputs after load", 64'(vis), 64'h5AA5);
    check("R8", "blank released", 64'(drv_blank), 64'd0);
    check_intervals("bypass");
    @(negedge clk);
    latch_bypass = 1'b0; cur_xp = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_load(16'hA5C3, 1'b0, "mixed");
    t_load(16'hFFFF, 1'b0, "ones");
    t_load(16'h0000, 1'b0, "zeros");
    t_load(16'h0001, 1'b0, "first position");
    t_load(16'h8000, 1'b0, "last position");
    t_hold_old();
    t_busy_ignore();
    t_back_to_back();
    t_bypass();
    t_load(16'h0180, 1'b0, "latched after bypass");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule